// File: doc/BRIEF.md
# Serial receive buffer with status flags

This block sits between the character deserializer of a serial port and the bus register interface. Each received character is offered as an 8-bit data byte plus four error bits (framing, parity, break, overrun). The block stores accepted characters in a 16-slot circular buffer tracked by a read pointer and an occupancy count. The bus side sees the oldest entry on a combinational output and removes it with a one-cycle pop strobe.

A mode input selects between buffered operation (up to 16 characters) and single-holding-register operation (one character). Any change of the mode input empties the buffer. The block keeps registered empty and full flags and a level-type receive interrupt request. It also keeps a sticky receive-status register that captures the error bits of the last popped entry.

A break event is stored as a status-only entry with a zero data byte. When the buffer cannot take a character, the character is discarded.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, rx_empty_o is 1, rx_full_o is 0, rx_irq_o is 0, rx_stat_o is 0, and push_ready_o is 1 while fifo_en_i is held at 0.
- R2: In buffered mode (fifo_en_i=1), entries leave in the order they were accepted. pop_data_o is {status[3:0], data[7:0]}, with status bit 0 = framing, 1 = parity, 2 = break, 3 = overrun.
- R3: In buffered mode a push is accepted only while the count is below 16. A push at count 16 is dropped, the count stays the same, and push_ready_o is 0.
- R4: In single mode (fifo_en_i=0) a push is accepted only at count 0. A second push is dropped, and rx_full_o is set after any accepted push in this mode.
- R5: rx_full_o is set when an accepted push brings the count to 16 in buffered mode. It is cleared by any pop that is not paired with an accepted push.
- R6: rx_empty_o is cleared by every accepted push. It is set when a pop leaves the count at 0.
- R7: A pop at count 0 leaves the read pointer and the count unchanged. pop_data_o keeps showing the entry at the read pointer.
- R8: rx_irq_o is set when a push alone makes the count equal the trigger level (default 1). It is cleared when a pop alone makes the count equal the trigger level minus one.
- R9: break_i pushes the entry 0x400 (break status bit set, data byte zero). It wins over push_i in the same cycle.
- R10: Every pop, including one at count 0, copies bits 11:8 of the entry at the read pointer into rx_stat_o. stat_clr_i clears rx_stat_o, and a pop in the same cycle takes precedence over the clear.
- R11: A cycle in which fifo_en_i differs from its value in the previous cycle resets the count and the read pointer to 0. Any push or pop in that cycle is discarded. The cycle also sets rx_empty_o and clears rx_full_o and rx_irq_o.
- R12: For a push and a pop in the same cycle, acceptance of the push is judged on the count before the pop. When both take effect, the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = buffered mode, 0 = single-holding mode |
| push_i | input | 1 | Received character strobe |
| push_data_i | input | 8 | Received data byte |
| push_stat_i | input | 4 | Error bits: framing, parity, break, overrun (bit 0..3) |
| break_i | input | 1 | Break event strobe |
| pop_i | input | 1 | Bus-side read strobe |
| stat_clr_i | input | 1 | Clear the receive-status register |
| push_ready_o | output | 1 | A push in this cycle would be accepted |
| pop_data_o | output | 12 | Entry at the read pointer |
| rx_empty_o | output | 1 | Receive-empty flag |
| rx_full_o | output | 1 | Receive-full flag |
| rx_irq_o | output | 1 | Receive interrupt request level |
| rx_stat_o | output | 4 | Error bits of the last popped entry |

## Verification
The assertions check the invariants on every cycle:
- the count never exceeds the capacity of the current mode;
- the full flag only stands at that capacity, and the empty flag tracks a zero count;
- a mode change always leaves an empty, quiet buffer;
- an empty pop never moves the pointer;
- the interrupt rises only at the trigger count.

Only the bench scenarios can show data ordering across the wrap of the circular store, the exact 0x400 break entry and its priority over a normal push, the stale entry returned by an empty pop, and the precedence of pop over status clear.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned STAT_W    = 4;
  localparam int unsigned ENT_W     = DATA_W + STAT_W;
  localparam int unsigned ST_FRAME  = 0;
  localparam int unsigned ST_PARITY = 1;
  localparam int unsigned ST_BREAK  = 2;
  localparam int unsigned ST_OVRUN  = 3;

  typedef struct packed {
    logic [STAT_W-1:0] stat;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  function automatic rx_entry_t break_entry();
    rx_entry_t e;
    e = '0;
    e.stat[ST_BREAK] = 1'b1;
    return e;
  endfunction
endpackage

// File: rtl/uart_rx_fifo_store.sv
module uart_rx_fifo_store
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [PW-1:0]   waddr_i,
  input  rx_entry_t       wdata_i,
  input  logic [PW-1:0]   raddr_i,
  output rx_entry_t       rdata_o
);
  rx_entry_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uart_rx_fifo_ctrl.sv
module uart_rx_fifo_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          push_req_i,
  input  logic          pop_i,
  output logic          push_ready_o,
  output logic          push_ok_o,
  output logic          pop_any_o,
  output logic          pop_eff_o,
  output logic          flush_o,
  output logic          fifo_en_q_o,
  output logic [PW-1:0] rptr_o,
  output logic [PW-1:0] wptr_o,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] count_nxt_o
);
  logic          en_q;
  logic [PW-1:0] rptr_q;
  logic [CW-1:0] count_q;
  logic          room;

  assign flush_o      = fifo_en_i ^ en_q;
  assign room         = en_q ? (count_q < CW'(DEPTH)) : (count_q == '0);
  assign push_ready_o = !flush_o && room;
  assign push_ok_o    = push_req_i && push_ready_o;
  assign pop_any_o    = pop_i && !flush_o;
  assign pop_eff_o    = pop_any_o && (count_q != '0);
  // power-of-two depth: the slot index wraps by truncation
  assign wptr_o       = rptr_q + count_q[PW-1:0];
  assign count_nxt_o  = flush_o ? '0
                      : count_q + CW'(push_ok_o) - CW'(pop_eff_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      en_q    <= fifo_en_i;
      rptr_q  <= flush_o ? '0 : rptr_q + PW'(pop_eff_o);
      count_q <= count_nxt_o;
    end
  end

  assign fifo_en_q_o = en_q;
  assign rptr_o      = rptr_q;
  assign count_o     = count_q;
endmodule

// File: rtl/uart_rx_fifo_flags.sv
module uart_rx_fifo_flags
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RX_TRIG = 1,
  parameter int unsigned CW      = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_q_i,
  input  logic              push_ok_i,
  input  logic              pop_any_i,
  input  logic              pop_eff_i,
  input  logic              flush_i,
  input  logic [CW-1:0]     count_nxt_i,
  input  logic [STAT_W-1:0] rd_stat_i,
  input  logic              stat_clr_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              irq_o,
  output logic [STAT_W-1:0] stat_o
);
  localparam logic [CW-1:0] CntFull = CW'(DEPTH);
  localparam logic [CW-1:0] CntTrig = CW'(RX_TRIG);
  localparam logic [CW-1:0] CntUntr = CW'(RX_TRIG - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else if (flush_i) begin
      empty_o <= 1'b1;
      full_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (push_ok_i)                               empty_o <= 1'b0;
      else if (pop_eff_i && count_nxt_i == '0)     empty_o <= 1'b1;

      if (push_ok_i && (!fifo_en_q_i || count_nxt_i == CntFull)) full_o <= 1'b1;
      else if (pop_any_i)                          full_o <= 1'b0;

      if (push_ok_i && !pop_eff_i && count_nxt_i == CntTrig)      irq_o <= 1'b1;
      else if (pop_eff_i && !push_ok_i && count_nxt_i == CntUntr) irq_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stat_o <= '0;
    else if (pop_any_i)  stat_o <= rd_stat_i;
    else if (stat_clr_i) stat_o <= '0;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RX_TRIG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_en_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [STAT_W-1:0] push_stat_i,
  input  logic              break_i,
  input  logic              pop_i,
  input  logic              stat_clr_i,
  output logic              push_ready_o,
  output logic [ENT_W-1:0]  pop_data_o,
  output logic              rx_empty_o,
  output logic              rx_full_o,
  output logic              rx_irq_o,
  output logic [STAT_W-1:0] rx_stat_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic          push_ok_w, pop_any_w, pop_eff_w, flush_w, en_q_w;
  logic [PW-1:0] rptr_w, wptr_w;
  logic [CW-1:0] count_w, count_nxt_w;
  rx_entry_t     wdata_w, rdata_w;

  assign wdata_w = break_i ? break_entry() : rx_entry_t'({push_stat_i, push_data_i});

  uart_rx_fifo_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni,
    .fifo_en_i,
    .push_req_i   (push_i | break_i),
    .pop_i,
    .push_ready_o,
    .push_ok_o    (push_ok_w),
    .pop_any_o    (pop_any_w),
    .pop_eff_o    (pop_eff_w),
    .flush_o      (flush_w),
    .fifo_en_q_o  (en_q_w),
    .rptr_o       (rptr_w),
    .wptr_o       (wptr_w),
    .count_o      (count_w),
    .count_nxt_o  (count_nxt_w)
  );

  uart_rx_fifo_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
    .clk_i, .rst_ni,
    .we_i    (push_ok_w),
    .waddr_i (wptr_w),
    .wdata_i (wdata_w),
    .raddr_i (rptr_w),
    .rdata_o (rdata_w)
  );

  uart_rx_fifo_flags #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG), .CW(CW)) u_flags (
    .clk_i, .rst_ni,
    .fifo_en_q_i (en_q_w),
    .push_ok_i   (push_ok_w),
    .pop_any_i   (pop_any_w),
    .pop_eff_i   (pop_eff_w),
    .flush_i     (flush_w),
    .count_nxt_i (count_nxt_w),
    .rd_stat_i   (rdata_w.stat),
    .stat_clr_i,
    .empty_o     (rx_empty_o),
    .full_o      (rx_full_o),
    .irq_o       (rx_irq_o),
    .stat_o      (rx_stat_o)
  );

  assign pop_data_o = rdata_w;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
  parameter int unsigned DEPTH   = 16,
  parameter int unsigned RX_TRIG = 1,
  parameter int unsigned PW      = $clog2(DEPTH),
  parameter int unsigned CW      = PW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fifo_en_i,
  input logic          pop_i,
  input logic          rx_empty_o,
  input logic          rx_full_o,
  input logic          rx_irq_o,
  input logic          fifo_en_q_i,
  input logic          push_ok_i,
  input logic [PW-1:0] rptr_i,
  input logic [CW-1:0] count_i
);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CW'(DEPTH));

  p_drop_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_q_i && fifo_en_i && count_i == CW'(DEPTH) && !pop_i) |=> count_i == CW'(DEPTH));

  p_single_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_q_i |-> count_i <= CW'(1));

  p_full_cnt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> (count_i == (fifo_en_q_i ? CW'(DEPTH) : CW'(1))));

  p_pop_clr_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && fifo_en_i == fifo_en_q_i && !push_ok_i) |=> !rx_full_o);

  p_empty_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o == (count_i == '0));

  p_empty_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && count_i == '0 && fifo_en_i == fifo_en_q_i) |=> $stable(rptr_i));

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_irq_o) |-> count_i == CW'(RX_TRIG));

  p_flush_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i != fifo_en_q_i) |=> (count_i == '0 && rptr_i == '0 && rx_empty_o && !rx_irq_o));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_en_i   (fifo_en_i),
  .pop_i       (pop_i),
  .rx_empty_o  (rx_empty_o),
  .rx_full_o   (rx_full_o),
  .rx_irq_o    (rx_irq_o),
  .fifo_en_q_i (en_q_w),
  .push_ok_i   (push_ok_w),
  .rptr_i      (rptr_w),
  .count_i     (count_w)
);

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/100ps
module uart_rx_fifo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fifo_en = 1'b0, push = 1'b0, brk = 1'b0, pop = 1'b0, sclr = 1'b0;
  logic [7:0]  pdata = '0;
  logic [3:0]  pstat = '0;
  logic        push_ready_o, rx_empty_o, rx_full_o, rx_irq_o;
  logic [11:0] pop_data_o;
  logic [3:0]  rx_stat_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [11:0] m [16];
  int          rp, cnt;
  bit          mq, e_empty, e_full, e_irq;
  logic [3:0]  e_stat;

  always #2.5 clk = ~clk;

  uart_rx_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .push_i(push),
    .push_data_i(pdata), .push_stat_i(pstat), .break_i(brk), .pop_i(pop),
    .stat_clr_i(sclr), .push_ready_o(push_ready_o), .pop_data_o(pop_data_o),
    .rx_empty_o(rx_empty_o), .rx_full_o(rx_full_o), .rx_irq_o(rx_irq_o),
    .rx_stat_o(rx_stat_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit room_ok(bit fl);
    return !fl && (mq ? (cnt < 16) : (cnt == 0));
  endfunction

  task automatic step(input string tag);
    bit fl, rdy, pok, pa, pe;
    logic [11:0] ent;
    #1;
    fl  = (fifo_en != mq);
    rdy = room_ok(fl);
    chk(tag, "push_ready", push_ready_o, rdy);
    chk(tag, "pop_data", pop_data_o, m[rp]);
    pok = (push || brk) && rdy;
    ent = brk ? 12'h400 : {pstat, pdata};
    pa  = pop && !fl;
    pe  = pa && cnt != 0;
    if (fl) begin
      cnt = 0; rp = 0; e_empty = 1; e_full = 0; e_irq = 0;
      if (sclr) e_stat = '0;
    end else begin
      int nc;
      if (pa) e_stat = m[rp][11:8];
      else if (sclr) e_stat = '0;
      if (pok) m[(rp + cnt) % 16] = ent;
      nc = cnt + int'(pok) - int'(pe);
      if (pok) e_empty = 0; else if (pe && nc == 0) e_empty = 1;
      if (pok && (!mq || nc == 16)) e_full = 1; else if (pa) e_full = 0;
      if (pok && !pe && nc == 1) e_irq = 1;
      else if (pe && !pok && nc == 0) e_irq = 0;
      if (pe) rp = (rp + 1) % 16;
      cnt = nc;
    end
    mq = fifo_en;
    @(posedge clk);
    #1;
    chk(tag, "empty", rx_empty_o, e_empty);
    chk(tag, "full", rx_full_o, e_full);
    chk(tag, "irq", rx_irq_o, e_irq);
    chk(tag, "stat", rx_stat_o, e_stat);
  endtask

  task automatic idle();
    push = 0; brk = 0; pop = 0; sclr = 0;
  endtask

  task automatic do_push(input string tag, input logic [7:0] d, input logic [3:0] s);
    idle(); push = 1; pdata = d; pstat = s; step(tag);
  endtask

  task automatic do_pop(input string tag);
    idle(); pop = 1; step(tag);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = '0;
    rp = 0; cnt = 0; mq = 0; e_empty = 1; e_full = 0; e_irq = 0; e_stat = '0;
    void'($urandom(32'd11));
    #12;
    // R1 reset state
    chk("R1", "empty", rx_empty_o, 1);
    chk("R1", "full", rx_full_o, 0);
    chk("R1", "irq", rx_irq_o, 0);
    chk("R1", "stat", rx_stat_o, 0);
    chk("R1", "push_ready", push_ready_o, 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R4 single-holding mode
    do_push("R4", 8'h5A, 4'b0001);
    do_push("R4", 8'hA5, 4'b0000);
    do_pop("R4");
    // R7 pop on empty
    do_pop("R7");
    // R10 pop wins over clear, then clear alone
    do_push("R10", 8'h33, 4'b1000);
    idle(); pop = 1; sclr = 1; step("R10");
    idle(); sclr = 1; step("R10");

    // R11 mode change to buffered
    idle(); fifo_en = 1; step("R11");
    // R5 fill to 16, R3 drop 17th, R2 drain in order
    for (int i = 0; i < 16; i++) do_push("R5", 8'(i * 7 + 1), 4'(i));
    do_push("R3", 8'hEE, 4'hF);
    for (int i = 0; i < 16; i++) do_pop("R2");
    do_pop("R7");

    // R9 break wins over push
    idle(); push = 1; brk = 1; pdata = 8'hFF; pstat = 4'b0011; step("R9");
    do_pop("R9");

    // R12 simultaneous push and pop
    do_push("R12", 8'h10, 4'h0);
    idle(); push = 1; pop = 1; pdata = 8'h11; pstat = 4'h2; step("R12");
    for (int i = 0; i < 15; i++) do_push("R12", 8'(8'h20 + i), 4'h0);
    idle(); push = 1; pop = 1; pdata = 8'h77; step("R12");
    for (int i = 0; i < 16; i++) do_pop("R6");

    // R8 interrupt level
    do_push("R8", 8'h44, 4'h0);
    do_push("R8", 8'h45, 4'h0);
    do_pop("R8");
    do_pop("R8");

    // R11 flush with content
    do_push("R11", 8'h01, 4'h0);
    do_push("R11", 8'h02, 4'h0);
    idle(); fifo_en = 0; push = 1; pdata = 8'h03; step("R11");
    idle(); step("R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      idle();
      push  = ($urandom % 2) == 0;
      brk   = ($urandom % 16) == 0;
      pop   = ($urandom % 3) == 0;
      sclr  = ($urandom % 16) == 0;
      pdata = 8'($urandom);
      pstat = 4'($urandom);
      if (($urandom % 80) == 0) fifo_en = ~fifo_en;
      step("R2");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule